// File: doc/BRIEF.md
# Remapping Unit Command and Status Register Block

This block is the register front end of a DMA address remapping unit. Software reaches it over a simple 32-bit register bus with byte, halfword and word accesses. Most words are plain storage. A few command words are handshakes: when one is written, the block at once copies the requested bits into the matching status field and clears the go bit. Software that polls the status word therefore sees each command done on its next read.

Global command bits are mirrored into global status. The root-pointer and queued-invalidation status bits are sticky. The context-cache and IOTLB invalidation requests complete in the same cycle, with the requested granularity reported back as the granularity actually used. The protected-memory status follows its enable bit. A write to the invalidation-queue tail sends a one-cycle trigger to the queue engine, but only once queued invalidation is on.

The block does no cache invalidation, fault recording or fault signalling. Apart from the two capability words, which always read as fixed parameter values, it does not protect fields that are meant to be read-only.

Top module: `rmu_cmd_regs`

## Requirements
- R1: After reset every register reads 0, except the capability words. Offsets 0x08/0x0C return `CAP_VALUE` low/high, and 0x10/0x14 return `ECAP_VALUE` low/high with bit 1 replaced by `QUEUED_INV`. Writes to the capability words never change what they read.
- R2: A write to global command (0x18) copies its bits 31, 29 and 27 into the same bits of global status (0x1C).
- R3: Command bit 30 sets status bit 30, which stays set across later command writes. Command bit 30 reads back as 0 after any command write.
- R4: Status bit 26 becomes 1 when command bit 26 is written as 1, `QUEUED_INV` is 1 and bit 26 was 0. Later command writes do not clear it.
- R5: A write to either half of the context command word (0x28 low, 0x2C high) copies high-word bits 30:29 into bits 28:27 and clears high-word bit 31.
- R6: A write to any of 0xC0..0xCF with IOTLB high-word (0xCC) bit 31 set does three things. It copies 0xCC bits 29:28 into bits 26:25 and clears bit 31. It clears all of 0xC4. It clears 0xC0 except bits 11:7. With bit 31 clear, the write is plain storage.
- R7: After a write to 0x64, bit 0 of that word equals its bit 31.
- R8: `regSize` selects the access width: 0 byte, 1 halfword, 2 word. A byte or halfword write takes the low 8 or 16 data bits, shifts them to byte lane `regAddr[1:0]` and stores the whole aligned word, with zeros in the other lanes.
- R9: A byte or halfword read returns the word shifted right by 8×`regAddr[1:0]`, masked to 8 or 16 bits and zero-extended.
- R10: An access with `regAddr` > `WINDOW_BYTES`-4 stores nothing and reads 0.
- R11: A write to 0x88 or 0x8C raises `queueKick` for exactly the following cycle when status bit 26 is set, and never otherwise.
- R12: `regRdata` updates on the clock edge that samples `regRd` and keeps its value while `regRd` is low.
- R13: Words without special behaviour (for example 0x58) read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regAddr | input | 12 | Byte offset of the access |
| regSize | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| regWdata | input | 32 | Write data, low-aligned for narrow writes |
| regRdata | output | 32 | Read data, registered |
| queueKick | output | 1 | One-cycle request to process the invalidation queue |

## Verification
A wrong handshake shows up at the ports on the first read after the command write: the status word or the go bit comes back with the wrong value. A lost sticky bit shows up only after a second command write, so the tests write commands in sequence and read status after each one. Aliasing of out-of-window addresses shows up as changed contents in low words, which later reads of those words expose. A wrong tail-trigger gate shows up in the cycle right after the tail write.

// File: rtl/rmu_regs_pkg.sv
package rmu_regs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  // word indices of the words with side effects
  localparam int CAP_I   = 'h08 >> 2;
  localparam int ECAP_I  = 'h10 >> 2;
  localparam int GCMD_I  = 'h18 >> 2;
  localparam int GSTS_I  = 'h1C >> 2;
  localparam int CCMD_I  = 'h28 >> 2;
  localparam int PMEN_I  = 'h64 >> 2;
  localparam int TAIL_I  = 'h88 >> 2;
  localparam int IVA_I   = 'hC0 >> 2;
  localparam int TLB_I   = 'hC8 >> 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef struct packed {
    logic              wrGo;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrWord;
    logic              hitGcmd;
    logic              hitCcmd;
    logic              hitPmen;
    logic              hitTlb;
    logic              hitTail;
    logic              rdGo;
    logic              rdInWin;
    logic [IDX_W-1:0]  rdIdx;
    logic [1:0]        rdLane;
    logic [1:0]        rdSize;
  } regStrobe_t;
endpackage

// File: rtl/rmu_ctrl.sv
module rmu_ctrl
  import rmu_regs_pkg::*;
#(
  parameter int unsigned WINDOW_BYTES = 256,
  parameter bit          QUEUED_INV   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regSize,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              qiEnabled,
  output regStrobe_t        strobe,
  output logic              queueKick
);
  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(WINDOW_BYTES - 4);

  logic             inWin;
  logic [IDX_W-1:0] idx;
  logic [1:0]       lane;
  logic [DATA_W-1:0] laneWord;
  logic             wrGo;

  assign inWin = (regAddr <= LAST_OFS);
  assign idx   = regAddr[ADDR_W-1:2];
  assign lane  = regAddr[1:0];
  assign wrGo  = regWr && inWin;

  // narrow writes: place the lane, zero the others (no read-modify-write)
  always_comb begin
    case (regSize)
      SZ_BYTE: laneWord = {24'b0, regWdata[7:0]}  << {lane, 3'b000};
      SZ_HALF: laneWord = {16'b0, regWdata[15:0]} << {lane, 3'b000};
      default: laneWord = regWdata;
    endcase
  end

  always_comb begin
    strobe.wrGo    = wrGo;
    strobe.wrIdx   = idx;
    strobe.wrWord  = laneWord;
    strobe.hitGcmd = wrGo && (idx == IDX_W'(GCMD_I));
    strobe.hitCcmd = wrGo && (idx[IDX_W-1:1] == (IDX_W-1)'(CCMD_I >> 1));
    strobe.hitPmen = wrGo && (idx == IDX_W'(PMEN_I));
    strobe.hitTlb  = wrGo && (idx[IDX_W-1:2] == (IDX_W-2)'(IVA_I >> 2));
    strobe.hitTail = wrGo && (idx[IDX_W-1:1] == (IDX_W-1)'(TAIL_I >> 1));
    strobe.rdGo    = regRd;
    strobe.rdInWin = inWin;
    strobe.rdIdx   = idx;
    strobe.rdLane  = lane;
    strobe.rdSize  = regSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) queueKick <= 1'b0;
    else       queueKick <= strobe.hitTail && qiEnabled && QUEUED_INV;
  end

  // R11
  kick_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueKick |-> $past(qiEnabled) && $past(regWr));

  // R11
  kick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueKick && !regWr |=> !queueKick);
endmodule

// File: rtl/rmu_regfile.sv
module rmu_regfile
  import rmu_regs_pkg::*;
#(
  parameter int unsigned WINDOW_BYTES = 256,
  parameter bit          QUEUED_INV   = 1'b1,
  parameter logic [63:0] CAP_VALUE    = 64'h0068_0000_0022_0462,
  parameter logic [63:0] ECAP_VALUE   = 64'h0000_0000_0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              qiEnabled
);
  localparam int REG_WORDS = WINDOW_BYTES / 4;
  localparam int WIDX      = $clog2(REG_WORDS);
  localparam logic [63:0] ECAP_EFF = {ECAP_VALUE[63:2], QUEUED_INV, ECAP_VALUE[0]};

  logic [DATA_W-1:0] regs [REG_WORDS];
  logic [DATA_W-1:0] nxt  [REG_WORDS];
  logic [WIDX-1:0]   wIdx;
  logic [WIDX-1:0]   rIdx;
  logic              unusedIdxBits;

  assign wIdx = strobe.wrIdx[WIDX-1:0];
  assign rIdx = strobe.rdIdx[WIDX-1:0];
  assign unusedIdxBits = ^{strobe.wrIdx[IDX_W-1:WIDX], strobe.rdIdx[IDX_W-1:WIDX]};

  always_comb begin
    logic [DATA_W-1:0] cmdW;
    logic [DATA_W-1:0] stsW;
    logic [DATA_W-1:0] hiW;
    nxt = regs;
    if (strobe.wrGo) nxt[wIdx] = strobe.wrWord;

    // global command mirrored into global status
    cmdW = nxt[GCMD_I];
    stsW = nxt[GSTS_I];
    if (strobe.hitGcmd) begin
      stsW[31] = cmdW[31];
      stsW[29] = cmdW[29];
      stsW[27] = cmdW[27];
      if (cmdW[30]) stsW[30] = 1'b1;
      if (QUEUED_INV && !stsW[26] && cmdW[26]) stsW[26] = 1'b1;
      cmdW[30] = 1'b0;
      nxt[GCMD_I] = cmdW;
      nxt[GSTS_I] = stsW;
    end

    // context command: report granularity, drop busy
    hiW = nxt[CCMD_I + 1];
    if (strobe.hitCcmd) begin
      hiW[28:27] = hiW[30:29];
      hiW[31]    = 1'b0;
      nxt[CCMD_I + 1] = hiW;
    end

    // IOTLB invalidate: report granularity, drop busy, clear address word
    hiW = nxt[TLB_I + 1];
    if (strobe.hitTlb && hiW[31]) begin
      hiW[26:25] = hiW[29:28];
      hiW[31]    = 1'b0;
      nxt[TLB_I + 1] = hiW;
      nxt[IVA_I]     = nxt[IVA_I] & 32'h0000_0F80;
      nxt[IVA_I + 1] = '0;
    end

    // protected memory status follows enable
    if (strobe.hitPmen) nxt[PMEN_I][0] = nxt[PMEN_I][31];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_WORDS; i++) regs[i] <= '0;
    end else begin
      regs <= nxt;
    end
  end

  // read path with capability words substituted
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] shWord;
  logic [DATA_W-1:0] rdVal;
  always_comb begin
    case (int'(rIdx))
      CAP_I:      srcWord = CAP_VALUE[31:0];
      CAP_I + 1:  srcWord = CAP_VALUE[63:32];
      ECAP_I:     srcWord = ECAP_EFF[31:0];
      ECAP_I + 1: srcWord = ECAP_EFF[63:32];
      default:    srcWord = regs[rIdx];
    endcase
    shWord = srcWord >> {strobe.rdLane, 3'b000};
    case (strobe.rdSize)
      SZ_BYTE: rdVal = {24'b0, shWord[7:0]};
      SZ_HALF: rdVal = {16'b0, shWord[15:0]};
      default: rdVal = srcWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdGo) rdData <= strobe.rdInWin ? rdVal : '0;
  end

  assign qiEnabled = regs[GSTS_I][26];

  logic rtpSts, gcmdGo, ccmdBusy, tlbBusy, pmenEn, pmenSts, stsDirect;
  assign rtpSts    = regs[GSTS_I][30];
  assign gcmdGo    = regs[GCMD_I][30];
  assign ccmdBusy  = regs[CCMD_I + 1][31];
  assign tlbBusy   = regs[TLB_I + 1][31];
  assign pmenEn    = regs[PMEN_I][31];
  assign pmenSts   = regs[PMEN_I][0];
  assign stsDirect = strobe.wrGo && (int'(wIdx) == GSTS_I);

  // R3
  rtp_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtpSts && !stsDirect |=> rtpSts);
  // R4
  qies_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    qiEnabled && !stsDirect |=> qiEnabled);
  // R3
  srtp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitGcmd |=> !gcmdGo);
  // R5
  ccmd_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitCcmd |=> !ccmdBusy);
  // R6
  tlb_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitTlb |=> !tlbBusy);
  // R7
  pmen_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitPmen |=> pmenSts == pmenEn);
  // R10
  oow_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdGo && !strobe.rdInWin |=> rdData == '0);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdGo |=> $stable(rdData));
endmodule

// File: rtl/rmu_cmd_regs.sv
module rmu_cmd_regs
  import rmu_regs_pkg::*;
#(
  parameter int unsigned WINDOW_BYTES = 256,
  parameter bit          QUEUED_INV   = 1'b1,
  parameter logic [63:0] CAP_VALUE    = 64'h0068_0000_0022_0462,
  parameter logic [63:0] ECAP_VALUE   = 64'h0000_0000_0000_1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [11:0] regAddr,
  input  logic [1:0]  regSize,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        queueKick
);
  regStrobe_t strobe;
  logic       qiEnabled;

  rmu_ctrl #(
    .WINDOW_BYTES(WINDOW_BYTES),
    .QUEUED_INV  (QUEUED_INV)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regSize  (regSize),
    .regWdata (regWdata),
    .qiEnabled(qiEnabled),
    .strobe   (strobe),
    .queueKick(queueKick)
  );

  rmu_regfile #(
    .WINDOW_BYTES(WINDOW_BYTES),
    .QUEUED_INV  (QUEUED_INV),
    .CAP_VALUE   (CAP_VALUE),
    .ECAP_VALUE  (ECAP_VALUE)
  ) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdData   (regRdata),
    .qiEnabled(qiEnabled)
  );
endmodule

// File: tb/rmu_cmd_regs_tb.sv
module rmu_cmd_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [11:0] regAddr = '0;
  logic [1:0]  regSize = 2'd2;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        queueKick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic lastKick;

  always #5 clk = ~clk;

  rmu_cmd_regs dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regSize(regSize), .regWdata(regWdata),
    .regRdata(regRdata), .queueKick(queueKick)
  );

  // {req[3:0], isRead, size[1:0], addr[11:0], data[31:0], expect[31:0]}
  localparam int NV = 43;
  localparam logic [82:0] VEC [NV] = '{
    {4'd2,  1'b0, 2'd2, 12'h018, 32'hA800_0000, 32'h0},          // R2
    {4'd2,  1'b1, 2'd2, 12'h01C, 32'h0,         32'hA800_0000},  // R2
    {4'd3,  1'b0, 2'd2, 12'h018, 32'h4000_0000, 32'h0},          // R3
    {4'd3,  1'b1, 2'd2, 12'h01C, 32'h0,         32'h4000_0000},  // R3
    {4'd3,  1'b1, 2'd2, 12'h018, 32'h0,         32'h0},          // R3 go bit cleared
    {4'd4,  1'b0, 2'd2, 12'h018, 32'h0400_0000, 32'h0},          // R4
    {4'd4,  1'b1, 2'd2, 12'h01C, 32'h0,         32'h4400_0000},  // R4
    {4'd4,  1'b0, 2'd2, 12'h018, 32'h8000_0000, 32'h0},          // R4 sticky
    {4'd4,  1'b1, 2'd2, 12'h01C, 32'h0,         32'hC400_0000},  // R4 R3 sticky
    {4'd2,  1'b1, 2'd2, 12'h018, 32'h0,         32'h8000_0000},  // R2
    {4'd5,  1'b0, 2'd2, 12'h02C, 32'hE000_0000, 32'h0},          // R5
    {4'd5,  1'b1, 2'd2, 12'h02C, 32'h0,         32'h7800_0000},  // R5
    {4'd5,  1'b0, 2'd2, 12'h028, 32'h1234_5678, 32'h0},          // R5 low half
    {4'd5,  1'b1, 2'd2, 12'h028, 32'h0,         32'h1234_5678},  // R5
    {4'd5,  1'b0, 2'd2, 12'h02C, 32'hA000_0000, 32'h0},          // R5
    {4'd5,  1'b1, 2'd2, 12'h02C, 32'h0,         32'h2800_0000},  // R5
    {4'd6,  1'b0, 2'd2, 12'h0C0, 32'hFFFF_FFFF, 32'h0},          // R6 idle
    {4'd6,  1'b0, 2'd2, 12'h0C4, 32'h1234_5678, 32'h0},          // R6
    {4'd6,  1'b1, 2'd2, 12'h0C0, 32'h0,         32'hFFFF_FFFF},  // R6
    {4'd6,  1'b1, 2'd2, 12'h0C4, 32'h0,         32'h1234_5678},  // R6
    {4'd6,  1'b0, 2'd2, 12'h0CC, 32'hB000_0000, 32'h0},          // R6 go
    {4'd6,  1'b1, 2'd2, 12'h0CC, 32'h0,         32'h3600_0000},  // R6
    {4'd6,  1'b1, 2'd2, 12'h0C0, 32'h0,         32'h0000_0F80},  // R6
    {4'd6,  1'b1, 2'd2, 12'h0C4, 32'h0,         32'h0},          // R6
    {4'd7,  1'b0, 2'd2, 12'h064, 32'h8000_0000, 32'h0},          // R7
    {4'd7,  1'b1, 2'd2, 12'h064, 32'h0,         32'h8000_0001},  // R7
    {4'd7,  1'b0, 2'd2, 12'h064, 32'h0000_0001, 32'h0},          // R7
    {4'd7,  1'b1, 2'd2, 12'h064, 32'h0,         32'h0},          // R7
    {4'd8,  1'b0, 2'd0, 12'h041, 32'h0000_12AB, 32'h0},          // R8 byte
    {4'd8,  1'b1, 2'd2, 12'h040, 32'h0,         32'h0000_AB00},  // R8
    {4'd8,  1'b0, 2'd1, 12'h042, 32'hFFFF_BEEF, 32'h0},          // R8 half
    {4'd8,  1'b1, 2'd2, 12'h040, 32'h0,         32'hBEEF_0000},  // R8
    {4'd9,  1'b1, 2'd0, 12'h043, 32'h0,         32'h0000_00BE},  // R9
    {4'd9,  1'b1, 2'd1, 12'h042, 32'h0,         32'h0000_BEEF},  // R9
    {4'd9,  1'b1, 2'd0, 12'h041, 32'h0,         32'h0000_0000},  // R9
    {4'd1,  1'b0, 2'd2, 12'h008, 32'hFFFF_FFFF, 32'h0},          // R1
    {4'd1,  1'b1, 2'd2, 12'h008, 32'h0,         32'h0022_0462},  // R1
    {4'd10, 1'b0, 2'd2, 12'h100, 32'h5555_5555, 32'h0},          // R10
    {4'd10, 1'b1, 2'd2, 12'h000, 32'h0,         32'h0},          // R10
    {4'd10, 1'b0, 2'd0, 12'h0FD, 32'h0000_0077, 32'h0},          // R10
    {4'd10, 1'b1, 2'd2, 12'h0FC, 32'h0,         32'h0},          // R10
    {4'd10, 1'b1, 2'd2, 12'h140, 32'h0,         32'h0},          // R10 alias of 0x40
    {4'd13, 1'b0, 2'd2, 12'h058, 32'hCAFE_F00D, 32'h0}           // R13
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regSize = s; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    lastKick = queueKick;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a; regSize = s;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic [31:0] rd;
    doReset();
    // R1 reset state
    check("R1 kick", {31'b0, queueKick}, 32'h0);
    doRead(12'h018, 2'd2, rd); check("R1 gcmd", rd, 32'h0);
    doRead(12'h01C, 2'd2, rd); check("R1 gsts", rd, 32'h0);
    doRead(12'h02C, 2'd2, rd); check("R1 ccmd", rd, 32'h0);
    doRead(12'h0CC, 2'd2, rd); check("R1 iotlb", rd, 32'h0);
    doRead(12'h008, 2'd2, rd); check("R1 cap lo", rd, 32'h0022_0462);
    doRead(12'h00C, 2'd2, rd); check("R1 cap hi", rd, 32'h0068_0000);
    doRead(12'h010, 2'd2, rd); check("R1 ecap lo", rd, 32'h0000_1002);

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      if (v[78]) begin
        doRead(v[75:64], v[77:76], rd);
        check($sformatf("vector %0d R%0d", i, v[82:79]), rd, v[31:0]);
      end else begin
        doWrite(v[75:64], v[77:76], v[63:32]);
      end
    end
    doRead(12'h058, 2'd2, rd); check("R13 storage", rd, 32'hCAFE_F00D);

    // R12 hold while idle
    repeat (3) @(negedge clk);
    check("R12 hold", regRdata, 32'hCAFE_F00D);

    // R11 tail trigger
    doReset();
    doWrite(12'h088, 2'd2, 32'h10);
    check("R11 no kick before enable", {31'b0, lastKick}, 32'h0);
    doWrite(12'h018, 2'd2, 32'h0400_0000);
    doWrite(12'h088, 2'd2, 32'h20);
    check("R11 kick low half", {31'b0, lastKick}, 32'h1);
    @(negedge clk);
    check("R11 kick one cycle", {31'b0, queueKick}, 32'h0);
    doWrite(12'h08C, 2'd2, 32'h0);
    check("R11 kick high half", {31'b0, lastKick}, 32'h1);
    doWrite(12'h080, 2'd2, 32'h30);
    check("R11 head no kick", {31'b0, lastKick}, 32'h0);
    doWrite(12'h018, 2'd2, 32'h0);
    doRead(12'h01C, 2'd2, rd); check("R4 survives zero cmd", rd, 32'h0400_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule